// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This peripheral counts down in half-second steps and, if software fails to service it in time, raises a reset request. Software programs it through three 16-bit registers on a 2-byte stride. The control register at offset 0x00 holds the timeout, output routing, run and low-power-pause fields. The service register at 0x02 accepts the two-word key sequence that restarts the count. The status register at 0x04 reports whether the last reset came from a timeout. The half-second tick comes from a prescaler that divides the peripheral clock by a parameter.

The timer is designed to be hard to defeat. Once it is started it cannot be stopped until a reset. The low-power pause option can be chosen only once after reset. A single stray write cannot restart the count, because a restart needs both words of the sequence in order. Two reset inputs are kept apart. The power-on reset clears everything. The system reset, which the reset output usually drives, leaves the timeout record intact so that software can read it after reboot.

Top module: `wdt_periph`

## Requirements
- R1: After power-on reset the control and status registers read 0x0000, and both expiry outputs are low.
- R2: The control register (offset 0x00) reads back as: timeout N in bits 15:8, route select in bit 3, run in bit 2, pause-in-low-power in bit 0. All other bits read 0.
- R3: Setting run loads the count from N. The first expiry then comes exactly (N+1)*HALF_SEC_CYCLES clock cycles after the write cycle, so N=0 gives one tick and N=255 gives 256 ticks.
- R4: Writing 0x5555 and then 0xAAAA to the service register (offset 0x02) restarts the full period, counted from the cycle of the 0xAAAA write. Writes to other registers between the two words do not break the sequence.
- R5: A service write that is not the expected next word returns the sequence to waiting for 0x5555. This includes a second 0x5555 or any other value. A later 0xAAAA alone then restarts nothing.
- R6: Writing 0 to the run bit after it has been set has no effect. The bit reads 1 and the count continues.
- R7: The pause bit takes only the first control write after reset. While it is 1 and low_power is high, the count freezes. While it is 0, low_power has no effect.
- R8: A new timeout written while running does not change the current period. It is used from the next restart, including the automatic restart that follows an expiry.
- R9: On expiry with route select 0, wdog_rst_o goes high for exactly RST_HOLD_CYCLES cycles. With route select 1, tout_ext_o pulses instead and wdog_rst_o stays low.
- R10: Status bit 1 (offset 0x04) becomes 1 on expiry. It stays 1 through a system reset, and only power-on reset clears it.
- R11: While the run bit is 0, neither expiry output ever goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the timeout record |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| low_power | input | 1 | Low-power mode indication |
| wdog_rst_o | output | 1 | Reset request pulse on expiry |
| tout_ext_o | output | 1 | Alternate expiry pulse when route select is set |

## Verification
The hardest situations to reach are a frozen count, which needs low_power held while the pause bit is set, and a sequence that a stray word has broken. The stimulus therefore places an exact number of paused cycles, or a chosen run of service words, inside a single countdown window. The predicted expiry cycle is then moved by exactly that amount, or not moved at all. A timeout rewritten mid-period is checked across two consecutive expiries, so that the automatic restart is seen to take the new value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int TO_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SVC  = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;

    localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

    localparam int BIT_PAUSE = 0;
    localparam int BIT_RUN   = 2;
    localparam int BIT_ROUTE = 3;
    localparam int BIT_FLAG  = 1;

    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_e;

    typedef struct packed {
        logic [TO_W-1:0] tmo;
        logic            route;
        logic            run;
        logic            pause;
    } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (clear) begin
            pre_d.cnt = '0;
        end else if (run) begin
            if (pre_q.cnt == LAST) begin
                pre_d.cnt = '0;
                tick      = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R7: a paused prescaler does not advance
    a_r7_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(pre_q.cnt));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_svc,
    input  logic [REG_W-1:0] wdata,
    output logic             fire
);
    typedef struct packed {
        seq_e st;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        fire  = 1'b0;
        if (wr_svc) begin
            if (seq_q.st == SEQ_ARMED && wdata == KEY_FIRE) begin
                fire     = 1'b1;
                seq_d.st = SEQ_IDLE;
            end else if (seq_q.st == SEQ_IDLE && wdata == KEY_ARM) begin
                seq_d.st = SEQ_ARMED;
            end else begin
                seq_d.st = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE};
        else        seq_q <= seq_d;
    end

    // R5: any service write while armed consumes the arming
    a_r5_one_shot_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_svc && seq_q.st == SEQ_ARMED) |=> (seq_q.st == SEQ_IDLE));
    // R4: a restart is only ever requested by a service write
    a_r4_fire_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> wr_svc);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int DIV  = 4,
    parameter int HOLD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            freeze,
    input  logic            reload_req,
    input  logic            route_ext,
    input  logic [TO_W-1:0] load_val,
    output logic            expire_o,
    output logic            rst_o,
    output logic            ext_o
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [TO_W-1:0] cnt;
        logic [HW-1:0]   hold;
        logic            to_ext;
    } cd_s;

    cd_s cd_d, cd_q;
    logic tick, run, pre_clr, expire;

    assign run     = enable && !freeze;
    assign pre_clr = !enable || reload_req;

    wdt_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (pre_clr),
        .tick  (tick)
    );

    always_comb begin
        cd_d   = cd_q;
        expire = tick && (cd_q.cnt == '0);
        if (!enable || reload_req || expire) begin
            cd_d.cnt = load_val;
        end else if (tick) begin
            cd_d.cnt = cd_q.cnt - 1'b1;
        end
        if (expire) begin
            cd_d.hold   = HW'(HOLD);
            cd_d.to_ext = route_ext;
        end else if (cd_q.hold != '0) begin
            cd_d.hold = cd_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign expire_o = expire;
    assign rst_o    = (cd_q.hold != '0) && !cd_q.to_ext;
    assign ext_o    = (cd_q.hold != '0) &&  cd_q.to_ext;

    // R9: expiry starts a pulse on exactly one of the two outputs
    a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (rst_o || ext_o));
    a_r9_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_o && ext_o));
    // R11: a stopped timer keeps both outputs low
    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !(rst_o || ext_o));
    // R7: a frozen count holds its value
    a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && freeze && !reload_req) |=> $stable(cd_q.cnt));
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph
    import wdt_pkg::*;
#(
    parameter int HALF_SEC_CYCLES = 125_000_000,
    parameter int RST_HOLD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              low_power,
    output logic              wdog_rst_o,
    output logic              tout_ext_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  lock;
    } regs_s;

    regs_s regs_d, regs_q;
    logic  flag_d, flag_q;
    logic  rst_n, ctrl_hit, svc_hit, fire, expire;

    assign rst_n    = por_n & sys_rst_n;
    assign ctrl_hit = wr_en && (addr == OFS_CTRL);
    assign svc_hit  = wr_en && (addr == OFS_SVC);

    always_comb begin
        regs_d = regs_q;
        if (ctrl_hit) begin
            regs_d.ctrl.tmo   = wdata[REG_W-1 -: TO_W];
            regs_d.ctrl.route = wdata[BIT_ROUTE];
            regs_d.ctrl.run   = regs_q.ctrl.run | wdata[BIT_RUN];
            if (!regs_q.lock) regs_d.ctrl.pause = wdata[BIT_PAUSE];
            regs_d.lock = 1'b1;
        end
        flag_d = flag_q | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    wdt_key_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_svc (svc_hit),
        .wdata  (wdata),
        .fire   (fire)
    );

    wdt_countdown #(
        .DIV  (HALF_SEC_CYCLES),
        .HOLD (RST_HOLD_CYCLES)
    ) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (regs_q.ctrl.run),
        .freeze     (regs_q.ctrl.pause && low_power),
        .reload_req (fire),
        .route_ext  (regs_q.ctrl.route),
        .load_val   (regs_d.ctrl.tmo),
        .expire_o   (expire),
        .rst_o      (wdog_rst_o),
        .ext_o      (tout_ext_o)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[REG_W-1 -: TO_W] = regs_q.ctrl.tmo;
                rdata[BIT_ROUTE]       = regs_q.ctrl.route;
                rdata[BIT_RUN]         = regs_q.ctrl.run;
                rdata[BIT_PAUSE]       = regs_q.ctrl.pause;
            end
            OFS_STAT: rdata[BIT_FLAG] = flag_q;
            default:  rdata = '0;
        endcase
    end

    // R6: the run bit never falls except by reset
    a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl.run |=> regs_q.ctrl.run);
    // R7: the pause choice is frozen after the first control write
    a_r7_pause_locked: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.lock |=> $stable(regs_q.ctrl.pause));
    // R10: the timeout record survives everything but power-on reset
    a_r10_flag_kept: assert property (@(posedge clk) disable iff (!por_n)
        flag_q |=> flag_q);
endmodule

// File: tb/wdt_periph_tb.sv
module wdt_periph_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV  = 4;
    localparam int HOLD = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        low_power = 1'b0;
    logic        wdog_rst_o, tout_ext_o;

    always #2 clk = ~clk;

    wdt_periph #(.HALF_SEC_CYCLES(DIV), .RST_HOLD_CYCLES(HOLD)) u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .low_power(low_power),
        .wdog_rst_o(wdog_rst_o), .tout_ext_o(tout_ext_o)
    );

    typedef struct {
        longint cyc;
        bit     ext;
        string  req;
    } ev_t;

    ev_t    exp_q[$];
    longint cyc = 0;
    int     checks = 0, errors = 0, unexpected = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic push(longint c, bit e, string req);
        ev_t ev;
        ev.cyc = c; ev.ext = e; ev.req = req;
        exp_q.push_back(ev);
    endtask

    task automatic wait_done();
        wait (exp_q.size() == 0);
        do @(negedge clk); while (wdog_rst_o || tout_ext_o);
    endtask

    task automatic sys_reset();
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
    endtask

    // monitor: pops an expected event on every rising output
    logic prev_r = 1'b0, prev_e = 1'b0;
    int   hi_len = 0;
    always @(negedge clk) begin
        if ((wdog_rst_o && !prev_r) || (tout_ext_o && !prev_e)) begin
            if (exp_q.size() == 0) begin
                unexpected++;
                checks++; errors++;
                $display("FAIL R11: unexpected pulse at cycle %0d, expected none", cyc);
            end else begin
                ev_t ev;
                ev = exp_q.pop_front();
                chk({ev.req, " expiry cycle"}, cyc, ev.cyc);
                chk("R9 output route", longint'(tout_ext_o), longint'(ev.ext));
            end
        end
        if (wdog_rst_o || tout_ext_o) begin
            hi_len++;
        end else if (prev_r || prev_e) begin
            chk("R9 pulse width", hi_len, HOLD);
            hi_len = 0;
        end
        prev_r = wdog_rst_o;
        prev_e = tout_ext_o;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        longint c;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1: reset state
        rd_chk("R1 ctrl", 4'h0, 16'h0000);
        rd_chk("R1 status", 4'h4, 16'h0000);
        chk("R1 outputs", {wdog_rst_o, tout_ext_o}, 2'b00);

        // R3 / R2 / R7: N=2, low_power ignored without pause
        wr(4'h0, 16'h0204);
        c = cyc;
        push(c + 3 * DIV, 1'b0, "R3");
        low_power = 1'b1;
        repeat (5) @(negedge clk);
        low_power = 1'b0;
        rd_chk("R2 ctrl readback", 4'h0, 16'h0204);
        wait_done();
        rd_chk("R10 flag set", 4'h4, 16'h0002);
        wr(4'h0, 16'h0200);
        rd_chk("R6 run stays set", 4'h0, 16'h0204);
        sys_reset();
        rd_chk("R10 ctrl cleared by system reset", 4'h0, 16'h0000);
        rd_chk("R10 flag kept", 4'h4, 16'h0002);

        // R4: valid sequence with an intervening control write
        wr(4'h0, 16'h0104);
        wr(4'h2, 16'h5555);
        wr(4'h0, 16'h0104);
        wr(4'h2, 16'hAAAA);
        c = cyc;
        push(c + 2 * DIV, 1'b0, "R4");
        wait_done();
        sys_reset();

        // R5: broken sequences restart nothing
        wr(4'h0, 16'h0304);
        c = cyc;
        push(c + 4 * DIV, 1'b0, "R5");
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        wait_done();
        sys_reset();

        // R8: new timeout used from the automatic restart on
        wr(4'h0, 16'h0104);
        c = cyc;
        push(c + 2 * DIV, 1'b0, "R8 first");
        wr(4'h0, 16'h0304);
        push(c + 2 * DIV + 4 * DIV, 1'b0, "R8 second");
        wait_done();
        rd_chk("R8 ctrl readback", 4'h0, 16'h0304);
        sys_reset();

        // R7: pause during low power, write-once pause bit
        wr(4'h0, 16'h0105);
        c = cyc;
        push(c + 2 * DIV + 10, 1'b0, "R7");
        low_power = 1'b1;
        repeat (10) @(negedge clk);
        low_power = 1'b0;
        wr(4'h0, 16'h0104);
        rd_chk("R7 pause locked", 4'h0, 16'h0105);
        wait_done();
        sys_reset();

        // R9 / R3: route select, N=0 boundary
        wr(4'h0, 16'h000C);
        c = cyc;
        push(c + DIV, 1'b1, "R9");
        wait_done();
        sys_reset();

        // R11: stopped timer stays quiet
        repeat (40) @(negedge clk);
        chk("R11 no pulse while stopped", unexpected, 0);

        // R10: power-on reset clears the record
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd_chk("R10 flag cleared by power-on", 4'h4, 16'h0000);
        chk("R3 all expiries seen", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule